// File: doc/BRIEF.md
# Clock Output Divider Network

This block turns one fast oscillator clock into a set of related clocks. A three-bit divider chain advances on every oscillator cycle. An optional extra halving stage sits in front of it, chosen by a divide-select input. Outputs taken from successive chain bits give a double-rate clock, a main-rate clock and a half-rate clock. The main rate fans out to several in-phase copies and to one complemented copy. The oscillator itself is treated as a plain digital clock input.

For static test, a path-enable input can switch the oscillator path off. The chain then steps once per rising edge of a sync input, chosen from two by a reference-select input. The sync input is sampled in the oscillator clock domain, and in this mode every clock output takes the opposite polarity. A single active-low input acts as both output enable and reset. While it is low, every output enable is deasserted and the divider state is cleared. The outputs are modelled as separate data and enable signals, so the block stays synthesizable.

Top module: `clk_div_network`

## Requirements
- R1: With the oscillator path on and divide-select low, `q_dbl` toggles on every `osc_clk` cycle. `q_main` has a period of 4 cycles and `q_half` has a period of 8 cycles. Starting from reset, the chain state after k advances is k modulo 8, and its bits 0, 1 and 2 drive `q_dbl`, `q_main` and `q_half`.
- R2: With divide-select high, the chain advances only on every second step: the 2nd, 4th, and so on after reset. This halves every output rate and keeps the 2:1 and 1:2 ratios.
- R3: Every bit of `q_main` carries the same value, and `q_inv` is always its complement.
- R4: While `oe_rst_n` is low, all bits of `out_en` are 0 in the same cycle. At the next `osc_clk` rising edge the chain is cleared, even if an advance was due.
- R5: While `oe_rst_n` is high, all bits of `out_en` are 1. The bit order is `q_main[NUM_MAIN-1:0]`, then `q_inv`, then `q_dbl`, then `q_half`.
- R6: After reset with the oscillator path on, `q_dbl`, `q_main` and `q_half` are 0 and `q_inv` is 1.
- R7: With the oscillator path off, the chain steps once for each rising edge of the selected sync input. A rising edge sampled high at one `osc_clk` edge, after being low at the edge before, updates the outputs at that same edge. Without such an edge, the outputs hold.
- R8: `ref_sel` = 0 selects `sync_a` and `ref_sel` = 1 selects `sync_b`. Activity on the input that is not selected has no effect.
- R9: With the oscillator path off, `q_dbl`, `q_main` and `q_half` are the complement of their oscillator-path values for the same chain state. After reset they are therefore 1, and `q_inv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock; all state is clocked by it |
| oe_rst_n | input | 1 | Active-low output enable and synchronous divider reset |
| osc_path_en | input | 1 | 1: chain steps on each oscillator cycle; 0: steps on sync edges with outputs inverted |
| ref_sel | input | 1 | Picks the sync input: 0 = sync_a, 1 = sync_b |
| sync_a | input | 1 | Sync/test clock input 0 |
| sync_b | input | 1 | Sync/test clock input 1 |
| div_sel | input | 1 | 1 inserts an extra divide-by-two ahead of the chain |
| q_main | output | NUM_MAIN | In-phase main-rate outputs |
| q_inv | output | 1 | Complemented main-rate output |
| q_dbl | output | 1 | Output at twice the main rate |
| q_half | output | 1 | Output at half the main rate |
| out_en | output | NUM_MAIN+3 | Per-output drive enables |

## Verification
The collision that matters is a reset arriving in the same cycle as a chain advance. The bench runs the chain freely with the oscillator path on, so an advance is due at every edge, and lowers `oe_rst_n` in the middle of that run. It judges the result twice. First, the enables must drop right away. Second, the outputs must show the cleared state after the next edge and not the advanced one. A second overlap appears with the oscillator path off: a step on the selected sync edge meets the extra halving stage. The edge counts over windows with both divide settings expose any advance that is lost or doubled.

// File: rtl/cdn_pkg.sv
// Package cdn_pkg
// Shared constants and types for the clock output divider network.
// Assumes the chain is exactly three bits: double, main and half rate.
package cdn_pkg;
    localparam int CHAIN_W  = 3;
    localparam int DBL_BIT  = 0;
    localparam int MAIN_BIT = 1;
    localparam int HALF_BIT = 2;

    typedef logic [CHAIN_W-1:0] chain_t;
endpackage

// File: rtl/cdn_tick_gen.sv
// Module cdn_tick_gen
// Produces the step strobe for the divider logic. With the oscillator path
// on, it strobes every cycle. With it off, it strobes once per rising edge
// of the selected sync input, sampled in the oscillator clock domain.
// Assumes the sync inputs are slow compared with osc_clk.
module cdn_tick_gen (
    input  logic osc_clk,
    input  logic osc_path_en,
    input  logic ref_sel,
    input  logic sync_a,
    input  logic sync_b,
    output logic tick
);
    logic sync_sel;
    logic sync_prev;

    // Purpose: 2:1 selection of the sync source.
    always_comb sync_sel = ref_sel ? sync_b : sync_a;

    // Purpose: remember the last sampled sync level. There is deliberately no
    // reset, so a level that is already high at release is not taken as an edge.
    always_ff @(posedge osc_clk) begin
        sync_prev <= sync_sel;
    end

    // Purpose: choose between the free-running strobe and the sync-edge strobe.
    always_comb tick = osc_path_en ? 1'b1 : (sync_sel & ~sync_prev);
endmodule

// File: rtl/cdn_prescale.sv
// Module cdn_prescale
// Optional divide-by-two ahead of the chain. When div_sel is high, only
// every second step strobe is passed on, starting with the second one
// after reset. Assumes a synchronous active-low reset.
module cdn_prescale (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic tick,
    input  logic div_sel,
    output logic adv
);
    logic phase_q;

    // Purpose: toggle the halving phase on each step strobe.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (tick) begin
            phase_q <= ~phase_q;
        end
    end

    // Purpose: pass every strobe, or only those on the odd phase.
    always_comb adv = tick & (~div_sel | phase_q);
endmodule

// File: rtl/cdn_divchain.sv
// Module cdn_divchain
// Binary divider chain. Each bit runs at half the rate of the bit below it.
// It is cleared synchronously, so every output starts from a known phase.
module cdn_divchain
    import cdn_pkg::*;
(
    input  logic   osc_clk,
    input  logic   rst_n,
    input  logic   adv,
    output chain_t chain
);
    // Purpose: step the chain once per advance strobe.
    always_ff @(posedge osc_clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (adv) begin
            chain <= chain + CHAIN_W'(1);
        end
    end
endmodule

// File: rtl/cdn_outstage.sv
// Module cdn_outstage
// Maps the chain bits onto the output set. It applies the test-mode
// polarity flip, fans out the main rate and drives the enables.
// Purely combinational; assumes chain comes straight from flops.
module cdn_outstage
    import cdn_pkg::*;
#(
    parameter int NUM_MAIN = 5
) (
    input  chain_t                chain,
    input  logic                  osc_path_en,
    input  logic                  oe_rst_n,
    output logic [NUM_MAIN-1:0]   q_main,
    output logic                  q_inv,
    output logic                  q_dbl,
    output logic                  q_half,
    output logic [NUM_MAIN+2:0]   out_en
);
    localparam int NUM_OUT = NUM_MAIN + 3;

    logic flip;
    logic main_lvl;

    // Purpose: test mode inverts every clock output.
    always_comb flip = ~osc_path_en;

    // Purpose: rate outputs taken from the chain bits.
    always_comb begin
        main_lvl = chain[MAIN_BIT] ^ flip;
        q_dbl    = chain[DBL_BIT]  ^ flip;
        q_half   = chain[HALF_BIT] ^ flip;
        q_inv    = ~main_lvl;
    end

    // Purpose: fan out the main rate to each in-phase output.
    for (genvar g = 0; g < NUM_MAIN; g++) begin : g_main
        assign q_main[g] = main_lvl;
    end

    // Purpose: every output is enabled exactly when not in reset.
    always_comb out_en = {NUM_OUT{oe_rst_n}};
endmodule

// File: rtl/clk_div_network.sv
// Module clk_div_network (top)
// Derives double, main, inverted-main and half-rate clocks from osc_clk,
// with optional extra halving and a sync-driven test mode. Assumes the
// oscillator is modelled as a digital clock and all state shares osc_clk.
module clk_div_network
    import cdn_pkg::*;
#(
    parameter int NUM_MAIN = 5
) (
    input  logic                osc_clk,
    input  logic                oe_rst_n,
    input  logic                osc_path_en,
    input  logic                ref_sel,
    input  logic                sync_a,
    input  logic                sync_b,
    input  logic                div_sel,
    output logic [NUM_MAIN-1:0] q_main,
    output logic                q_inv,
    output logic                q_dbl,
    output logic                q_half,
    output logic [NUM_MAIN+2:0] out_en
);
    logic   tick;
    logic   adv;
    chain_t chain;

    cdn_tick_gen u_tick (
        .osc_clk     (osc_clk),
        .osc_path_en (osc_path_en),
        .ref_sel     (ref_sel),
        .sync_a      (sync_a),
        .sync_b      (sync_b),
        .tick        (tick)
    );

    cdn_prescale u_pre (
        .osc_clk (osc_clk),
        .rst_n   (oe_rst_n),
        .tick    (tick),
        .div_sel (div_sel),
        .adv     (adv)
    );

    cdn_divchain u_chain (
        .osc_clk (osc_clk),
        .rst_n   (oe_rst_n),
        .adv     (adv),
        .chain   (chain)
    );

    cdn_outstage #(.NUM_MAIN(NUM_MAIN)) u_out (
        .chain       (chain),
        .osc_path_en (osc_path_en),
        .oe_rst_n    (oe_rst_n),
        .q_main      (q_main),
        .q_inv       (q_inv),
        .q_dbl       (q_dbl),
        .q_half      (q_half),
        .out_en      (out_en)
    );
endmodule

// File: rtl/clk_div_network_chk.sv
// Module clk_div_network_chk
// Property checker for clk_div_network, attached through bind below.
// Observes only the ports of the top module.
module clk_div_network_chk #(
    parameter int NUM_MAIN = 5
) (
    input logic                osc_clk,
    input logic                oe_rst_n,
    input logic                osc_path_en,
    input logic                ref_sel,
    input logic                sync_a,
    input logic                sync_b,
    input logic                div_sel,
    input logic [NUM_MAIN-1:0] q_main,
    input logic                q_inv,
    input logic                q_dbl,
    input logic                q_half,
    input logic [NUM_MAIN+2:0] out_en
);
    logic sel_w;

    // Purpose: model of the selected sync level, built from the ports.
    always_comb sel_w = ref_sel ? sync_b : sync_a;

    // Purpose: combinational enable and grouping rules.
    always_comb begin
        if (!oe_rst_n) begin
            assert_oe_off_R4: assert (out_en == '0);
        end else begin
            assert_oe_on_R5: assert (&out_en);
        end
        assert_group_R3: assert ((q_main == {NUM_MAIN{q_main[0]}}) && (q_inv == ~q_main[0]));
    end

    // R1: oscillator path, no extra halving: double-rate output toggles every cycle
    assert_dbl_toggle_R1: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
        (osc_path_en && $past(osc_path_en) && !$past(div_sel) && $past(oe_rst_n))
        |-> (q_dbl != $past(q_dbl)));

    // R1: main output changes only where the double-rate output falls
    assert_main_on_dbl_fall_R1: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
        (osc_path_en && $past(osc_path_en) && $past(oe_rst_n) && !$stable(q_main[0]))
        |-> $fell(q_dbl));

    // R1: half-rate output changes only where the main output falls
    assert_half_on_main_fall_R1: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
        (osc_path_en && $past(osc_path_en) && $past(oe_rst_n) && !$stable(q_half))
        |-> $fell(q_main[0]));

    // R7: test mode without a sync rising edge leaves the outputs unchanged
    assert_bypass_idle_R7: assert property (@(posedge osc_clk) disable iff (!oe_rst_n)
        (!osc_path_en && !$past(osc_path_en) && $past(oe_rst_n)
         && !($past(sel_w) && !$past(sel_w, 2)))
        |-> ($stable(q_dbl) && $stable(q_main[0]) && $stable(q_half)));
endmodule

bind clk_div_network clk_div_network_chk #(.NUM_MAIN(NUM_MAIN)) u_chk (
    .osc_clk     (osc_clk),
    .oe_rst_n    (oe_rst_n),
    .osc_path_en (osc_path_en),
    .ref_sel     (ref_sel),
    .sync_a      (sync_a),
    .sync_b      (sync_b),
    .div_sel     (div_sel),
    .q_main      (q_main),
    .q_inv       (q_inv),
    .q_dbl       (q_dbl),
    .q_half      (q_half),
    .out_en      (out_en)
);

// File: tb/clk_div_network_tb_top.sv
// Bench for clk_div_network. A vector table gives the edge-count windows;
// directed tests then cover reset, test mode and source selection.
module clk_div_network_tb_top;
    localparam int NUM_MAIN = 5;
    localparam int NUM_OUT  = NUM_MAIN + 3;

    typedef struct packed {
        logic       byp;
        logic       div;
        logic       rsel;
        logic [7:0] units;
        logic [7:0] e_dbl;
        logic [7:0] e_main;
        logic [7:0] e_half;
    } vec_t;

    // units: oscillator cycles in normal mode, sync pulses in test mode
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b0, 8'd64,  8'd32, 8'd16, 8'd8},
        '{1'b0, 1'b1, 1'b0, 8'd64,  8'd16, 8'd8,  8'd4},
        '{1'b1, 1'b0, 1'b0, 8'd32,  8'd16, 8'd8,  8'd4},
        '{1'b1, 1'b0, 1'b1, 8'd32,  8'd16, 8'd8,  8'd4},
        '{1'b1, 1'b1, 1'b1, 8'd32,  8'd8,  8'd4,  8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd128, 8'd32, 8'd16, 8'd8}
    };

    logic                osc_clk = 1'b0;
    logic                oe_rst_n = 1'b0;
    logic                osc_path_en = 1'b1;
    logic                ref_sel = 1'b0;
    logic                sync_a = 1'b0;
    logic                sync_b = 1'b0;
    logic                div_sel = 1'b0;
    logic [NUM_MAIN-1:0] q_main;
    logic                q_inv;
    logic                q_dbl;
    logic                q_half;
    logic [NUM_OUT-1:0]  out_en;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    int   n_dbl, n_main, n_half, n_bad;
    logic p_dbl, p_main, p_half;

    always #4 osc_clk = ~osc_clk;

    clk_div_network #(.NUM_MAIN(NUM_MAIN)) dut_i (
        .osc_clk     (osc_clk),
        .oe_rst_n    (oe_rst_n),
        .osc_path_en (osc_path_en),
        .ref_sel     (ref_sel),
        .sync_a      (sync_a),
        .sync_b      (sync_b),
        .div_sel     (div_sel),
        .q_main      (q_main),
        .q_inv       (q_inv),
        .q_dbl       (q_dbl),
        .q_half      (q_half),
        .out_en      (out_en)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count rising edges since the last sample and note any grouping error.
    task automatic sample_step();
        if (q_dbl && !p_dbl)      n_dbl++;
        if (q_main[0] && !p_main) n_main++;
        if (q_half && !p_half)    n_half++;
        if ((q_main != {NUM_MAIN{q_main[0]}}) || (q_inv != ~q_main[0])) n_bad++;
        p_dbl  = q_dbl;
        p_main = q_main[0];
        p_half = q_half;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge osc_clk);
        oe_rst_n    = 1'b0;
        osc_path_en = ~v.byp;
        div_sel     = v.div;
        ref_sel     = v.rsel;
        sync_a      = 1'b0;
        sync_b      = 1'b0;
        @(negedge osc_clk);
        @(negedge osc_clk);
        oe_rst_n = 1'b1;
        #1;
        n_dbl = 0; n_main = 0; n_half = 0; n_bad = 0;
        p_dbl = q_dbl; p_main = q_main[0]; p_half = q_half;
        if (!v.byp) begin
            repeat (int'(v.units)) begin
                @(negedge osc_clk);
                sample_step();
            end
        end else begin
            for (int p = 0; p < int'(v.units); p++) begin
                for (int ph = 0; ph < 4; ph++) begin
                    @(negedge osc_clk);
                    sample_step();
                    if (v.rsel) begin
                        sync_b = (ph < 2);
                        sync_a = ~sync_a;
                    end else begin
                        sync_a = (ph < 2);
                        sync_b = ~sync_b;
                    end
                end
            end
            repeat (2) begin
                @(negedge osc_clk);
                sample_step();
            end
        end
        // R1 R2 R7 R8 R9: edge counts over the window
        check(n_dbl == int'(v.e_dbl),   v.div ? "R2" : (v.byp ? "R7" : "R1"),
              $sformatf("vec%0d dbl rises", idx), n_dbl, int'(v.e_dbl));
        check(n_main == int'(v.e_main), v.div ? "R2" : (v.byp ? "R8" : "R1"),
              $sformatf("vec%0d main rises", idx), n_main, int'(v.e_main));
        check(n_half == int'(v.e_half), v.byp ? "R9" : "R1",
              $sformatf("vec%0d half rises", idx), n_half, int'(v.e_half));
        check(n_bad == 0, "R3", $sformatf("vec%0d group mismatches", idx), n_bad, 0);
    endtask

    initial begin
        // Table walk
        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i], i);
        end

        // Reset state with the oscillator path on
        @(negedge osc_clk);
        oe_rst_n = 1'b0; osc_path_en = 1'b1; div_sel = 1'b0; ref_sel = 1'b0;
        sync_a = 1'b0; sync_b = 1'b0;
        @(negedge osc_clk);
        @(negedge osc_clk);
        check(out_en == '0, "R4", "out_en in reset", int'(out_en), 0);
        check({q_dbl, q_main[0], q_half, q_inv} == 4'b0001, "R6", "reset outputs {dbl,main,half,inv}",
              int'({q_dbl, q_main[0], q_half, q_inv}), 1);

        // Release: enables on
        oe_rst_n = 1'b1;
        #1;
        check(out_en == {NUM_OUT{1'b1}}, "R5", "out_en after release",
              int'(out_en), int'({NUM_OUT{1'b1}}));

        // Five advances: chain = 5 -> dbl 1, main 0, half 1
        repeat (5) @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half, q_inv} == 4'b1011, "R1", "phase after 5 steps",
              int'({q_dbl, q_main[0], q_half, q_inv}), 11);

        // R4: reset in the same cycle as a due advance
        oe_rst_n = 1'b0;
        #1;
        check(out_en == '0, "R4", "out_en drops at once", int'(out_en), 0);
        @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half} == 3'b000, "R4", "cleared instead of advanced",
              int'({q_dbl, q_main[0], q_half}), 0);

        // R9: test-mode reset polarity
        osc_path_en = 1'b0;
        #1;
        check({q_dbl, q_main[0], q_half, q_inv} == 4'b1110, "R9", "test-mode reset outputs",
              int'({q_dbl, q_main[0], q_half, q_inv}), 14);
        @(negedge osc_clk);
        oe_rst_n = 1'b1;

        // R7: no sync edge -> hold
        repeat (10) @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half} == 3'b111, "R7", "hold without sync edge",
              int'({q_dbl, q_main[0], q_half}), 7);

        // R8: unselected input toggling has no effect
        for (int k = 0; k < 20; k++) begin
            @(negedge osc_clk);
            sync_b = ~sync_b;
        end
        @(negedge osc_clk);
        sync_b = 1'b0;
        @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half} == 3'b111, "R8", "unselected sync ignored",
              int'({q_dbl, q_main[0], q_half}), 7);

        // R7: one sync edge -> one step, visible after the sampling edge
        sync_a = 1'b1;
        @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half} == 3'b011, "R7", "single step on sync edge",
              int'({q_dbl, q_main[0], q_half}), 3);
        repeat (5) @(negedge osc_clk);
        check({q_dbl, q_main[0], q_half} == 3'b011, "R7", "high level gives no more steps",
              int'({q_dbl, q_main[0], q_half}), 3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule